// File: doc/BRIEF.md
# Triple Buffer Role Rotator

This block owns three identical memory banks of N words each and hands them, in turn, to three clients: a serial sample loader that fills the next symbol, a processing element that works on the current symbol in place, and a serial reader that drains the finished result of the symbol before that. Each bank serves exactly one client at a time. A crossbar steers each client's address, write data and read data to the bank that currently holds its role.

When the symbol-start strobe arrives, the roles advance. The bank that was being loaded becomes the working memory. The working bank becomes the readout bank. The readout bank is released to take the next input. No word is ever moved between banks: a symbol travels from input through computation to output purely by reassignment. The current owner of each role is reported as a bank index.

A symbol-start that arrives while the processing element has not yet raised its done flag still rotates, but it produces a one-cycle overrun pulse. The loader and the reader use internal sequential address counters that restart at every rotation. The whole block runs on one clock. The reset input is asynchronous and active low, and it is released through an internal two-stage synchronizer.

Top module: `tribuf_rotator`

## Requirements
- R1: Once reset has been released, the loader role is on bank 0, the working role on bank 1 and the readout role on bank 2. Both `rd_ready` and `overrun` are low.
- R2: A cycle with `sym_start` high moves the roles on the next clock edge. The new working bank is the previous loader bank, the new readout bank is the previous working bank, and the new loader bank is the previous readout bank.
- R3: The role indices change only on a `sym_start` cycle. At all times the three indices are distinct values in the range 0 to 2.
- R4: `overrun` is high for exactly the one cycle that follows a `sym_start` cycle in which `fft_done` was low, and it is low otherwise. The rotation is carried out in both cases.
- R5: `rd_ready` is low until the second rotation after reset. From the second rotation on it stays high.
- R6: Each `ld_valid` cycle writes `ld_data` into the loader bank at a sequential address. The address starts at 0 after reset and after every rotation. Once N words have been written, further `ld_valid` cycles are ignored until the next rotation.
- R7: A cycle with `pe_we` high writes `pe_wdata` at `pe_addr` in the working bank. A cycle with `pe_we` low reads that bank at `pe_addr`, and `pe_rdata` shows the word from the next cycle on.
- R8: Each `rd_en` cycle reads the readout bank at a sequential address, and `rd_data` shows the word from the next cycle on. The address starts at 0 after every rotation, steps by one per read, and wraps from N-1 to 0.
- R9: Samples loaded in one symbol period come out of the reader two rotations later in load order. Any word the processing element wrote during the middle period appears in place of the loaded word at that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_start | input | 1 | Symbol boundary strobe, rotates roles |
| fft_done | input | 1 | Processing element has finished the current symbol |
| ld_valid | input | 1 | Loader sample strobe |
| ld_data | input | DATA_W | Loader sample |
| pe_addr | input | log2(N) | Processing element word address |
| pe_we | input | 1 | Processing element write enable (read when low) |
| pe_wdata | input | DATA_W | Processing element write data |
| pe_rdata | output | DATA_W | Processing element read data, one cycle latency |
| rd_en | input | 1 | Reader strobe |
| rd_data | output | DATA_W | Reader data, one cycle latency |
| rd_ready | output | 1 | The readout bank holds a finished symbol |
| overrun | output | 1 | Rotation happened before the done flag was set |
| ld_bank | output | 2 | Bank index holding the loader role |
| pe_bank | output | 2 | Bank index holding the working role |
| rd_bank | output | 2 | Bank index holding the readout role |

## Verification
The assertions check the role bookkeeping on every cycle. They check that the three indices always form a permutation of 0 to 2, that they hold still between strobes, and that they rotate by exactly one position after each strobe. They also check the overrun pulse, the monotonic rise of `rd_ready`, and the restart of the loader count after a rotation. Only the bench's scenarios can show that data actually flows through the crossbar. Such a scenario follows samples through two rotations and confirms that the processing element's overwrites, the ignored surplus loads and the wrapping reader addresses all land in the right bank at the right address.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;
  localparam int unsigned NUM_BANKS = 3;
  typedef logic [1:0] bank_idx_t;
  localparam bank_idx_t LD_RESET_BANK = 2'd0;
  localparam bank_idx_t PE_RESET_BANK = 2'd1;
  localparam bank_idx_t RD_RESET_BANK = 2'd2;
  localparam logic [1:0] ROTATIONS_TO_READY = 2'd2;
endpackage

// File: rtl/tribuf_rst_sync.sv
module tribuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tribuf_role_ctrl.sv
module tribuf_role_ctrl
  import tribuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rotate,
  input  logic      fft_done,
  output bank_idx_t ld_idx,
  output bank_idx_t pe_idx,
  output bank_idx_t rd_idx,
  output logic      ready,
  output logic      overrun
);
  bank_idx_t  ld_q, pe_q, rd_q;
  bank_idx_t  ld_d, pe_d, rd_d;
  logic [1:0] rot_q, rot_d;
  logic       ovr_q, ovr_d;

  // next-state: roles advance one place on each strobe
  always_comb begin
    ld_d  = ld_q;
    pe_d  = pe_q;
    rd_d  = rd_q;
    rot_d = rot_q;
    ovr_d = rotate && !fft_done;
    if (rotate) begin
      pe_d = ld_q;
      rd_d = pe_q;
      ld_d = rd_q;
      if (rot_q != ROTATIONS_TO_READY) rot_d = rot_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= LD_RESET_BANK;
      pe_q  <= PE_RESET_BANK;
      rd_q  <= RD_RESET_BANK;
      rot_q <= 2'd0;
      ovr_q <= 1'b0;
    end else begin
      ld_q  <= ld_d;
      pe_q  <= pe_d;
      rd_q  <= rd_d;
      rot_q <= rot_d;
      ovr_q <= ovr_d;
    end
  end

  assign ld_idx  = ld_q;
  assign pe_idx  = pe_q;
  assign rd_idx  = rd_q;
  assign ready   = (rot_q == ROTATIONS_TO_READY);
  assign overrun = ovr_q;
endmodule

// File: rtl/tribuf_seq_counter.sv
module tribuf_seq_counter #(
  parameter int unsigned DEPTH = 16,
  parameter bit          WRAP  = 1'b1,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  generate
    if (WRAP) begin : g_wrap
      always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = (cnt_q == CNT_W'(DEPTH - 1)) ? '0 : cnt_q + 1'b1;
      end
    end else begin : g_sat
      always_comb begin
        cnt_d = cnt_q;
        if (clr) cnt_d = '0;
        else if (inc && (cnt_q != CNT_W'(DEPTH))) cnt_d = cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tribuf_bank.sv
module tribuf_bank #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata <= '0;
    else if (en && !we) rdata <= mem[addr];
  end
endmodule

// File: rtl/tribuf_rotator.sv
module tribuf_rotator
  import tribuf_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LCW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_start,
  input  logic              fft_done,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [AW-1:0]     pe_addr,
  input  logic              pe_we,
  input  logic [DATA_W-1:0] pe_wdata,
  output logic [DATA_W-1:0] pe_rdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ready,
  output logic              overrun,
  output logic [1:0]        ld_bank,
  output logic [1:0]        pe_bank,
  output logic [1:0]        rd_bank
);
  logic      rst_sync_n;
  bank_idx_t ld_idx, pe_idx, rd_idx;
  bank_idx_t pe_sel_q, rd_sel_q;
  logic [LCW-1:0] ld_cnt;
  logic [AW-1:0]  rd_cnt;
  logic           ld_full, ld_wr;

  logic              bk_en    [NUM_BANKS];
  logic              bk_we    [NUM_BANKS];
  logic [AW-1:0]     bk_addr  [NUM_BANKS];
  logic [DATA_W-1:0] bk_wdata [NUM_BANKS];
  logic [DATA_W-1:0] bk_rdata [NUM_BANKS];

  tribuf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tribuf_role_ctrl u_roles (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rotate   (sym_start),
    .fft_done (fft_done),
    .ld_idx   (ld_idx),
    .pe_idx   (pe_idx),
    .rd_idx   (rd_idx),
    .ready    (rd_ready),
    .overrun  (overrun)
  );

  assign ld_full = (ld_cnt == LCW'(DEPTH));
  assign ld_wr   = ld_valid && !ld_full;

  tribuf_seq_counter #(.DEPTH(DEPTH), .WRAP(1'b0), .CNT_W(LCW)) u_ld_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (sym_start),
    .inc   (ld_wr),
    .count (ld_cnt)
  );

  tribuf_seq_counter #(.DEPTH(DEPTH), .WRAP(1'b1), .CNT_W(AW)) u_rd_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (sym_start),
    .inc   (rd_en),
    .count (rd_cnt)
  );

  // crossbar: each bank takes the port of whichever role it holds
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_comb begin
        if (ld_idx == bank_idx_t'(b)) begin
          bk_en[b]    = ld_wr;
          bk_we[b]    = 1'b1;
          bk_addr[b]  = ld_cnt[AW-1:0];
          bk_wdata[b] = ld_data;
        end else if (pe_idx == bank_idx_t'(b)) begin
          bk_en[b]    = 1'b1;
          bk_we[b]    = pe_we;
          bk_addr[b]  = pe_addr;
          bk_wdata[b] = pe_wdata;
        end else begin
          bk_en[b]    = rd_en;
          bk_we[b]    = 1'b0;
          bk_addr[b]  = rd_cnt;
          bk_wdata[b] = '0;
        end
      end

      tribuf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (bk_en[b]),
        .we    (bk_we[b]),
        .addr  (bk_addr[b]),
        .wdata (bk_wdata[b]),
        .rdata (bk_rdata[b])
      );
    end
  endgenerate

  // read-return select follows the bank that was addressed a cycle earlier
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pe_sel_q <= PE_RESET_BANK;
      rd_sel_q <= RD_RESET_BANK;
    end else begin
      pe_sel_q <= pe_idx;
      rd_sel_q <= rd_idx;
    end
  end

  always_comb begin
    case (pe_sel_q)
      2'd0:    pe_rdata = bk_rdata[0];
      2'd1:    pe_rdata = bk_rdata[1];
      default: pe_rdata = bk_rdata[2];
    endcase
    case (rd_sel_q)
      2'd0:    rd_data = bk_rdata[0];
      2'd1:    rd_data = bk_rdata[1];
      default: rd_data = bk_rdata[2];
    endcase
  end

  assign ld_bank = ld_idx;
  assign pe_bank = pe_idx;
  assign rd_bank = rd_idx;
endmodule

// File: rtl/tribuf_rotator_chk.sv
module tribuf_rotator_chk #(
  parameter int unsigned LCW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sym_start,
  input logic           fft_done,
  input logic [1:0]     ld_bank,
  input logic [1:0]     pe_bank,
  input logic [1:0]     rd_bank,
  input logic           rd_ready,
  input logic           overrun,
  input logic [LCW-1:0] ld_cnt
);
  // R3: roles always form a permutation of the three banks
  a_r3_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_bank != pe_bank) && (pe_bank != rd_bank) && (ld_bank != rd_bank)
    && (ld_bank != 2'd3) && (pe_bank != 2'd3) && (rd_bank != 2'd3));

  // R2: one-step rotation after a strobe
  a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |=> (pe_bank == $past(ld_bank)) && (rd_bank == $past(pe_bank))
                  && (ld_bank == $past(rd_bank)));

  // R3: no change without a strobe
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_start |=> $stable(ld_bank) && $stable(pe_bank) && $stable(rd_bank));

  // R4: overrun pulse
  a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_start && !fft_done) |=> overrun);
  a_r4_overrun_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_start && !fft_done) |=> !overrun);

  // R5: ready rises only after a strobe and never falls
  a_r5_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ready) |-> $past(sym_start));
  a_r5_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> rd_ready);

  // R6: loader count restarts at each rotation
  a_r6_ld_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |=> (ld_cnt == '0));
endmodule

bind tribuf_rotator tribuf_rotator_chk #(.LCW(LCW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sym_start (sym_start),
  .fft_done  (fft_done),
  .ld_bank   (ld_bank),
  .pe_bank   (pe_bank),
  .rd_bank   (rd_bank),
  .rd_ready  (rd_ready),
  .overrun   (overrun),
  .ld_cnt    (ld_cnt)
);

// File: tb/tribuf_rotator_bench.sv
module tribuf_rotator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 24;
  localparam int N  = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_start = 0, fft_done = 0, ld_valid = 0, pe_we = 0, rd_en = 0;
  logic [W-1:0]  ld_data = '0, pe_wdata = '0;
  logic [AW-1:0] pe_addr = '0;
  logic [W-1:0]  pe_rdata, rd_data;
  logic rd_ready, overrun;
  logic [1:0] ld_bank, pe_bank, rd_bank;

  always #(CLK_PERIOD/2) clk = ~clk;

  tribuf_rotator #(.DATA_W(W), .DEPTH(N)) u_tribuf_rotator (
    .clk(clk), .rst_n(rst_n), .sym_start(sym_start), .fft_done(fft_done),
    .ld_valid(ld_valid), .ld_data(ld_data), .pe_addr(pe_addr), .pe_we(pe_we),
    .pe_wdata(pe_wdata), .pe_rdata(pe_rdata), .rd_en(rd_en), .rd_data(rd_data),
    .rd_ready(rd_ready), .overrun(overrun), .ld_bank(ld_bank), .pe_bank(pe_bank),
    .rd_bank(rd_bank)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] mdl [3][N];
  bit           mvalid [3][N];
  int m_ld = 0, m_pe = 1, m_rd = 2, m_rot = 0, m_lcnt = 0, m_rcnt = 0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ready(input int rots);
    return rots >= 2;
  endfunction

  task automatic check_roles(input string req);
    check(ld_bank == 2'(m_ld), req, W'(ld_bank), W'(m_ld));
    check(pe_bank == 2'(m_pe), req, W'(pe_bank), W'(m_pe));
    check(rd_bank == 2'(m_rd), req, W'(rd_bank), W'(m_rd));
  endtask

  task automatic load(input logic [W-1:0] d);
    ld_valid = 1; ld_data = d;
    @(negedge clk);
    ld_valid = 0;
    if (m_lcnt < N) begin
      mdl[m_ld][m_lcnt] = d; mvalid[m_ld][m_lcnt] = 1; m_lcnt++;
    end
  endtask

  task automatic pe_write(input int a, input logic [W-1:0] d);
    pe_we = 1; pe_addr = AW'(a); pe_wdata = d;
    @(negedge clk);
    pe_we = 0;
    mdl[m_pe][a] = d; mvalid[m_pe][a] = 1;
  endtask

  task automatic pe_read(input int a);
    pe_we = 0; pe_addr = AW'(a);
    @(negedge clk);
    if (mvalid[m_pe][a])
      check(pe_rdata === mdl[m_pe][a], "R7 pe read", pe_rdata, mdl[m_pe][a]);
  endtask

  task automatic rd_one(input string req);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    if (mvalid[m_rd][m_rcnt])
      check(rd_data === mdl[m_rd][m_rcnt], req, rd_data, mdl[m_rd][m_rcnt]);
    m_rcnt = (m_rcnt + 1) % N;
  endtask

  task automatic rotate(input bit done);
    int t;
    fft_done = done; sym_start = 1;
    @(negedge clk);
    sym_start = 0; fft_done = 0;
    t = m_rd; m_rd = m_pe; m_pe = m_ld; m_ld = t;
    m_rot++; m_lcnt = 0; m_rcnt = 0;
    for (int i = 0; i < N; i++) mvalid[m_ld][i] = 0;
    check_roles("R2 rotation");
    check(overrun == !done, "R4 overrun after strobe", W'(overrun), W'(!done));
    check(rd_ready == exp_ready(m_rot), "R5 ready", W'(rd_ready), W'(exp_ready(m_rot)));
    @(negedge clk);
    check(overrun == 1'b0, "R4 overrun one cycle", W'(overrun), '0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < 3; b++) for (int i = 0; i < N; i++) mvalid[b][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_roles("R1 reset roles");
    check(rd_ready == 0, "R1 reset ready", W'(rd_ready), '0);
    check(overrun == 0, "R1 reset overrun", W'(overrun), '0);
    for (int p = 0; p < 8; p++) begin
      int extra;
      extra = (p == 1) ? 3 : 0;
      for (int i = 0; i < N + extra; i++) load(W'($urandom));
      for (int k = 0; k < 3; k++) begin
        int a;
        a = int'($urandom % N);
        pe_read(a);
        pe_write(a, W'($urandom));
        pe_read(a);
      end
      if (p == 2) begin
        pe_write(0, 24'hA5A5A5);
        pe_write(N - 1, 24'h5A5A5A);
      end
      for (int i = 0; i < N + ((p == 4) ? 3 : 0); i++)
        rd_one((p == 4 && i >= N) ? "R8 reader wrap" :
               (p == 3) ? "R9 directed overwrite path" : "R9 data through roles");
      repeat (2) @(negedge clk);
      check_roles("R3 roles held");
      rotate(p != 3);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule